// File: doc/BRIEF.md
# Serial Meter-Word Output Interface

This block takes per-channel 16-bit two's complement meter words, together with one warning flag per channel, from a metering core. It streams them to external display logic over two serial lines: one for data and one for the flag. It has no clock of its own. The receiver supplies the bit clock, and the receiver's framing signals tell the block which channel slot is being read. Every slot is 32 bit-clock periods long. Inside the slot the 16-bit word is placed in one of two ways, chosen by a static pin:

- most significant bit first, starting at the first slot position;
- least significant bit first, ending at the last slot position.

The block has two framing modes. In the two-channel mode, the level of the frame clock picks the slot: high selects channel 0 and low selects channel 1. This gives two slots per frame at a bit clock of 64 times the frame rate. In the eight-channel mode, three channel-select lines give the slot's channel directly as a binary value from 0 to 7. These lines toggle at four, two and one times the frame rate, and the bit clock runs at 256 times the frame rate.

At the first bit of channel 0 in each frame, the block copies all words and flags into a shadow bank. A frame therefore never mixes values from two metering periods.

Top module: `meter_word_serializer`

## Requirements
- R1: While `rst_n` is low, `ser_data` and `ser_flag` are low, and the shadow bank is cleared. After reset, and before the first slot is seen, both outputs stay low.
- R2: In two-channel mode (`eight_ch_mode`=0), the slot index is sampled on each rising bit-clock edge. It is 0 when `frame_clk` is high and 1 when `frame_clk` is low. `chan_sel` has no effect in this mode.
- R3: In eight-channel mode (`eight_ch_mode`=1), the slot index is the binary value of `chan_sel` (bit 0 is least significant), sampled on each rising bit-clock edge. It selects channel 0 to 7 in any order. `frame_clk` has no effect in this mode.
- R4: The first rising edge at which the sampled index differs from the previous one is slot position 0. Each further rising edge with the same index adds one to the position. The bit for a position appears on `ser_data` at the falling edge that follows that rising edge.
- R5: With `msb_left`=1, positions 0 to 15 carry word bits 15 down to 0.
- R6: With `msb_left`=0, positions 16 to 31 carry word bits 0 up to 15.
- R7: Positions 0 to 31 that carry no word bit are driven low.
- R8: If a slot lasts longer than 32 rising edges, every position from 32 onward is driven low.
- R9: `ser_flag` carries the shadowed flag of the current slot's channel at every falling edge of that slot.
- R10: The shadow bank loads every word and flag at the rising edge where the index changes to 0 from any other value. A change to `meter_words` or `meter_flags` at any other time does not reach the outputs before the next such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock supplied by the receiver |
| rst_n | input | 1 | Asynchronous active-low reset |
| eight_ch_mode | input | 1 | 1: eight-channel framing, 0: two-channel framing |
| msb_left | input | 1 | 1: MSB first, left-justified; 0: LSB first, right-justified |
| frame_clk | input | 1 | Frame clock; in two-channel mode, high selects channel 0 |
| chan_sel | input | 3 | Channel-select lines used in eight-channel mode |
| meter_words | input | 128 | Channel c word at bits [16c+15:16c] |
| meter_flags | input | 8 | Channel c warning flag at bit c |
| ser_data | output | 1 | Serial word stream |
| ser_flag | output | 1 | Flag of the current slot's channel |

## Verification
Slot index and position are registered on a rising edge, and the matching data and flag bits leave on the next falling edge. Every result is therefore due half a bit clock after the rising edge that sampled its stimulus. A new word becomes visible only from the falling edge after the next frame-start rising edge. The bench drives stimulus shortly after each falling edge. It advances its own behavioural model at each rising edge, and compares both outputs against that model 1 ns after the following falling edge. At that point both outputs have settled and nothing is changing. Words are changed in the middle of frames, slot orders are permuted, and slots are stretched past 32 positions, so the shadow, ordering and overrun rules are all checked against that same half-cycle timing.

// File: rtl/meter_ser_pkg.sv
package meter_ser_pkg;

   localparam int MS_NCH       = 8;
   localparam int MS_WORD_BITS = 16;
   localparam int MS_SLOT_BITS = 32;

   // Width of a position counter that can hold 0..slot_bits inclusive.
   function automatic int pos_width(input int slot_bits);
      return $clog2(slot_bits + 1);
   endfunction

   typedef enum logic {
      LAYOUT_LSB_RIGHT = 1'b0,
      LAYOUT_MSB_LEFT  = 1'b1
   } layout_e;

endpackage

// File: rtl/meter_slot_tracker.sv
module meter_slot_tracker
   import meter_ser_pkg::*;
#(
   parameter  int NCH       = MS_NCH,
   parameter  int SLOT_BITS = MS_SLOT_BITS,
   localparam int SEL_BITS  = $clog2(NCH),
   localparam int POS_BITS  = pos_width(SLOT_BITS)
) (
   input  logic                bit_clk,
   input  logic                rst_n,
   input  logic                eight_ch_mode,
   input  logic                frame_clk,
   input  logic [SEL_BITS-1:0] chan_sel,
   output logic [SEL_BITS-1:0] idx_q,
   output logic [POS_BITS-1:0] pos_q,
   output logic                frame_start
);

   localparam logic [POS_BITS-1:0] POS_OVER = POS_BITS'(SLOT_BITS);

   logic [SEL_BITS-1:0] idx_in;
   logic                new_slot;

   always_comb begin
      if (eight_ch_mode) begin
         idx_in = chan_sel;
      end else begin
         idx_in = {{(SEL_BITS-1){1'b0}}, ~frame_clk};
      end
      new_slot    = (idx_in != idx_q);
      frame_start = new_slot && (idx_in == '0);
   end

   // Reset parks the tracker on the last slot in overrun, so the first
   // sampled channel 0 opens a frame.
   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '1;
         pos_q <= POS_OVER;
      end else begin
         idx_q <= idx_in;
         if (new_slot) begin
            pos_q <= '0;
         end else if (pos_q != POS_OVER) begin
            pos_q <= pos_q + 1'b1;
         end
      end
   end

   // R4: an index change always restarts the slot position.
   p_pos_restart_r4 : assert property (@(posedge bit_clk) disable iff (!rst_n)
      (idx_q != $past(idx_q)) |-> (pos_q == '0));

   // R8: the position saturates one past the last slot bit.
   p_pos_bound_r8 : assert property (@(posedge bit_clk) disable iff (!rst_n)
      (pos_q == POS_OVER) |=> (pos_q == POS_OVER) || (pos_q == '0));

endmodule

// File: rtl/meter_shadow_bank.sv
module meter_shadow_bank
   import meter_ser_pkg::*;
#(
   parameter int NCH       = MS_NCH,
   parameter int WORD_BITS = MS_WORD_BITS
) (
   input  logic                              bit_clk,
   input  logic                              rst_n,
   input  logic                              capture,
   input  logic [NCH*WORD_BITS-1:0]          words_flat,
   input  logic [NCH-1:0]                    flags_in,
   output logic [NCH-1:0][WORD_BITS-1:0]     words_q,
   output logic [NCH-1:0]                    flags_q
);

   logic [NCH-1:0][WORD_BITS-1:0] words_arr;

   for (genvar c = 0; c < NCH; c++) begin : g_unpack
      assign words_arr[c] = words_flat[c*WORD_BITS +: WORD_BITS];
   end

   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n) begin
         words_q <= '0;
         flags_q <= '0;
      end else if (capture) begin
         words_q <= words_arr;
         flags_q <= flags_in;
      end
   end

   // R10: the bank only moves on a frame-start capture.
   p_shadow_hold_r10 : assert property (@(posedge bit_clk) disable iff (!rst_n)
      !capture |=> $stable(words_q) && $stable(flags_q));

endmodule

// File: rtl/meter_bit_picker.sv
module meter_bit_picker
   import meter_ser_pkg::*;
#(
   parameter  int WORD_BITS = MS_WORD_BITS,
   parameter  int SLOT_BITS = MS_SLOT_BITS,
   localparam int POS_BITS  = pos_width(SLOT_BITS)
) (
   input  logic [WORD_BITS-1:0] word,
   input  logic [POS_BITS-1:0]  pos,
   input  logic                 msb_left,
   output logic                 bit_out
);

   localparam int PAD_BITS = SLOT_BITS - WORD_BITS;
   localparam logic [POS_BITS-1:0] POS_WORD = POS_BITS'(WORD_BITS);
   localparam logic [POS_BITS-1:0] POS_PAD  = POS_BITS'(PAD_BITS);
   localparam logic [POS_BITS-1:0] POS_SLOT = POS_BITS'(SLOT_BITS);
   localparam logic [POS_BITS-1:0] POS_TOP  = POS_BITS'(WORD_BITS - 1);

   layout_e              layout;
   logic                 hit;
   logic [POS_BITS-1:0]  off;

   always_comb begin
      layout = layout_e'(msb_left);
      if (layout == LAYOUT_MSB_LEFT) begin
         hit = (pos < POS_WORD);
         off = POS_TOP - pos;
      end else begin
         hit = (pos >= POS_PAD) && (pos < POS_SLOT);
         off = pos - POS_PAD;
      end
      bit_out = hit && |(word & (WORD_BITS'(1) << off));
   end

endmodule

// File: rtl/meter_word_serializer.sv
module meter_word_serializer
   import meter_ser_pkg::*;
#(
   parameter  int NCH       = MS_NCH,
   parameter  int WORD_BITS = MS_WORD_BITS,
   parameter  int SLOT_BITS = MS_SLOT_BITS,
   localparam int SEL_BITS  = $clog2(NCH)
) (
   input  logic                     bit_clk,
   input  logic                     rst_n,
   input  logic                     eight_ch_mode,
   input  logic                     msb_left,
   input  logic                     frame_clk,
   input  logic [SEL_BITS-1:0]      chan_sel,
   input  logic [NCH*WORD_BITS-1:0] meter_words,
   input  logic [NCH-1:0]           meter_flags,
   output logic                     ser_data,
   output logic                     ser_flag
);

   localparam int POS_BITS = pos_width(SLOT_BITS);
   localparam logic [POS_BITS-1:0] POS_WORD = POS_BITS'(WORD_BITS);
   localparam logic [POS_BITS-1:0] POS_PAD  = POS_BITS'(SLOT_BITS - WORD_BITS);
   localparam logic [POS_BITS-1:0] POS_OVER = POS_BITS'(SLOT_BITS);

   if (NCH < 2 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("NCH must be a power of two of at least 2");
   end
   if (WORD_BITS < 1) begin : g_bad_word
      $error("WORD_BITS must be positive");
   end
   if (SLOT_BITS < WORD_BITS) begin : g_bad_slot
      $error("SLOT_BITS must hold a whole word");
   end

   logic [SEL_BITS-1:0]            idx_q;
   logic [POS_BITS-1:0]            pos_q;
   logic                           frame_start;
   logic [NCH-1:0][WORD_BITS-1:0]  shadow_words;
   logic [NCH-1:0]                 shadow_flags;
   logic                           pick_bit;

   meter_slot_tracker #(
      .NCH       (NCH),
      .SLOT_BITS (SLOT_BITS)
   ) u_tracker (
      .bit_clk       (bit_clk),
      .rst_n         (rst_n),
      .eight_ch_mode (eight_ch_mode),
      .frame_clk     (frame_clk),
      .chan_sel      (chan_sel),
      .idx_q         (idx_q),
      .pos_q         (pos_q),
      .frame_start   (frame_start)
   );

   meter_shadow_bank #(
      .NCH       (NCH),
      .WORD_BITS (WORD_BITS)
   ) u_shadow (
      .bit_clk    (bit_clk),
      .rst_n      (rst_n),
      .capture    (frame_start),
      .words_flat (meter_words),
      .flags_in   (meter_flags),
      .words_q    (shadow_words),
      .flags_q    (shadow_flags)
   );

   meter_bit_picker #(
      .WORD_BITS (WORD_BITS),
      .SLOT_BITS (SLOT_BITS)
   ) u_picker (
      .word     (shadow_words[idx_q]),
      .pos      (pos_q),
      .msb_left (msb_left),
      .bit_out  (pick_bit)
   );

   // Launch on the falling edge so the receiver samples on its rising edge.
   always_ff @(negedge bit_clk or negedge rst_n) begin
      if (!rst_n) begin
         ser_data <= 1'b0;
         ser_flag <= 1'b0;
      end else begin
         ser_data <= pick_bit;
         ser_flag <= shadow_flags[idx_q];
      end
   end

   // R7: padding ahead of or behind the word stays low.
   p_pad_msb_r7 : assert property (@(negedge bit_clk) disable iff (!rst_n)
      (msb_left && pos_q >= POS_WORD && pos_q < POS_OVER) |=> !ser_data);

   p_pad_lsb_r7 : assert property (@(negedge bit_clk) disable iff (!rst_n)
      (!msb_left && pos_q < POS_PAD) |=> !ser_data);

   // R8: an over-long slot emits zeros.
   p_overrun_low_r8 : assert property (@(negedge bit_clk) disable iff (!rst_n)
      (pos_q == POS_OVER) |=> !ser_data);

   // R9: the flag line holds steady while the slot does not change.
   p_flag_steady_r9 : assert property (@(negedge bit_clk) disable iff (!rst_n)
      (idx_q == $past(idx_q)) |=> $stable(ser_flag));

endmodule

// File: tb/meter_word_serializer_bench.sv
module meter_word_serializer_bench;

   logic         bit_clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         eight_ch_mode = 1'b0;
   logic         msb_left = 1'b1;
   logic         frame_clk = 1'b0;
   logic [2:0]   chan_sel = 3'd0;
   logic [127:0] meter_words = '0;
   logic [7:0]   meter_flags = '0;
   logic         ser_data;
   logic         ser_flag;

   int    n_tests = 0;
   int    n_fail = 0;
   string phase_tag = "R1";

   // behavioural model state
   int    m_idx = 7;
   int    m_pos = 32;
   int    m_word [8];
   bit    m_flag [8];

   always #5 bit_clk = ~bit_clk;   // 100 MHz

   meter_word_serializer u_meter_word_serializer (
      .bit_clk       (bit_clk),
      .rst_n         (rst_n),
      .eight_ch_mode (eight_ch_mode),
      .msb_left      (msb_left),
      .frame_clk     (frame_clk),
      .chan_sel      (chan_sel),
      .meter_words   (meter_words),
      .meter_flags   (meter_flags),
      .ser_data      (ser_data),
      .ser_flag      (ser_flag)
   );

   task automatic check(input string what, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b at %0t", what, act, exp, $time);
      end
   endtask

   task automatic model_rise();
      int nidx;
      if (!rst_n) begin
         m_idx = 7;
         m_pos = 32;
         for (int c = 0; c < 8; c++) begin
            m_word[c] = 0;
            m_flag[c] = 1'b0;
         end
      end else begin
         nidx = eight_ch_mode ? int'(chan_sel) : (frame_clk ? 0 : 1);
         if (nidx != m_idx) begin
            m_pos = 0;
            if (nidx == 0) begin
               for (int c = 0; c < 8; c++) begin
                  m_word[c] = int'(meter_words[c*16 +: 16]);
                  m_flag[c] = meter_flags[c];
               end
            end
         end else if (m_pos < 32) begin
            m_pos++;
         end
         m_idx = nidx;
      end
   endtask

   task automatic compare();
      logic  exp_d;
      logic  exp_f;
      string region;
      string mode;
      mode = eight_ch_mode ? "R3" : "R2";
      if (!rst_n) begin
         check("R1 reset data", ser_data, 1'b0);
         check("R1 reset flag", ser_flag, 1'b0);
      end else begin
         exp_f = m_flag[m_idx];
         if (m_pos >= 32) begin
            exp_d = 1'b0; region = "R8";
         end else if (msb_left) begin
            if (m_pos < 16) begin
               exp_d = m_word[m_idx][15 - m_pos]; region = "R5";
            end else begin
               exp_d = 1'b0; region = "R7";
            end
         end else begin
            if (m_pos >= 16) begin
               exp_d = m_word[m_idx][m_pos - 16]; region = "R6";
            end else begin
               exp_d = 1'b0; region = "R7";
            end
         end
         check($sformatf("data R4 %s %s %s ch%0d pos%0d", region, mode, phase_tag,
                         m_idx, m_pos), ser_data, exp_d);
         check($sformatf("flag R9 %s %s ch%0d", mode, phase_tag, m_idx), ser_flag, exp_f);
      end
   endtask

   // Inputs are set by the caller just after a falling edge.
   task automatic step();
      @(posedge bit_clk);
      model_rise();
      @(negedge bit_clk);
      #1;
      compare();
   endtask

   task automatic new_values();
      for (int c = 0; c < 8; c++) begin
         meter_words[c*16 +: 16] = 16'($urandom);
      end
      meter_flags = 8'($urandom);
   endtask

   task automatic frame_2ch(input int hi_len, input int lo_len, input bit mid);
      for (int b = 0; b < hi_len + lo_len; b++) begin
         frame_clk = (b < hi_len);
         chan_sel  = 3'($urandom);
         if (b == 0 || (mid && (b == 5 || b == hi_len + 8))) new_values();
         step();
      end
   endtask

   task automatic slot_8ch(input int ch, input int len, input bit mid);
      for (int b = 0; b < len; b++) begin
         chan_sel  = 3'(ch);
         frame_clk = (ch < 4);
         if (mid && b == 7) new_values();
         step();
      end
   endtask

   task automatic frame_8ch(input bit mid);
      for (int s = 0; s < 8; s++) slot_8ch(s, 32, mid);
   endtask

   initial begin
      repeat (100000) @(posedge bit_clk);
      n_fail++;
      $display("FAIL watchdog all-R actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int order [8];
      order = '{0, 5, 2, 7, 1, 6, 3, 4};
      new_values();
      // R1: outputs low under reset
      phase_tag = "R1";
      @(negedge bit_clk);
      #1;
      for (int i = 0; i < 3; i++) step();
      rst_n = 1'b1;
      frame_clk = 1'b0;
      step();
      step();

      // R2 framing, both layouts
      phase_tag = "R2";
      msb_left = 1'b1;
      for (int f = 0; f < 3; f++) frame_2ch(32, 32, 1'b0);
      msb_left = 1'b0;
      for (int f = 0; f < 3; f++) frame_2ch(32, 32, 1'b0);

      // R10: mid-frame updates must wait for the next frame
      phase_tag = "R10";
      msb_left = 1'b1;
      for (int f = 0; f < 2; f++) frame_2ch(32, 32, 1'b1);
      msb_left = 1'b0;
      for (int f = 0; f < 2; f++) frame_2ch(32, 32, 1'b1);

      // R3 eight-channel framing
      phase_tag = "R3";
      eight_ch_mode = 1'b1;
      msb_left = 1'b1;
      new_values();
      for (int f = 0; f < 2; f++) frame_8ch(1'b1);
      msb_left = 1'b0;
      for (int f = 0; f < 2; f++) frame_8ch(1'b1);
      // R3: permuted slot order
      msb_left = 1'b1;
      for (int f = 0; f < 2; f++) begin
         for (int s = 0; s < 8; s++) slot_8ch(order[s], 32, 1'b1);
      end

      // R8: slots stretched past 32 positions
      phase_tag = "R8";
      slot_8ch(0, 40, 1'b0);
      slot_8ch(3, 36, 1'b1);
      msb_left = 1'b0;
      slot_8ch(0, 38, 1'b0);
      eight_ch_mode = 1'b0;
      frame_2ch(40, 40, 1'b1);
      msb_left = 1'b1;
      frame_2ch(45, 34, 1'b0);
      frame_2ch(32, 32, 1'b0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule